// File: doc/BRIEF.md
# Clock Output Enable Gating Controller

This block decides, for each differential clock output of a fanout/zero-delay buffer, whether the pair toggles or is parked with both legs low. It looks at a power-good/power-down input, a per-output active-high disable pin, a per-output software enable bit, a PLL lock flag and a configuration strap that picks PLL mode or bypass mode. It drives the gated true and complement legs in the output clock domain. Every asynchronous control is resynchronized before use, and the gate for each output only moves on a falling edge of the clock, so a start or a stop never leaves a shortened high pulse.

The first synchronized high on the power-good input starts the device and freezes the strap into a mode register. After that, a low on power-good is a power-down request and a later high leaves power-down, with the original mode kept. In PLL mode the outputs are held parked until lock is reported, and they are parked again if lock is lost. In bypass mode the PLL request is dropped and the outputs run without regard to lock. The analog PLL, the output drivers and their amplitude and slew settings are outside this block.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While power-good has not been high since reset (or is low before the first start), every `out_run` bit is 0, every `dif_t` and `dif_c` leg is 0 and `pll_on` is 0, whatever the other inputs do.
- R2: The strap `byp_strap` (1 = bypass mode, 0 = PLL mode) is sampled once, at the first synchronized high of `pwr_good` after reset; later strap changes, including changes made across a power-down exit, have no effect until the next reset.
- R3: After the first start, `pwr_good` low parks all outputs and drops `pll_on`, and disable pins and lock have no effect while it stays low; `pwr_good` high again resumes operation.
- R4: `pin_off[i]` = 1 parks output i; `pin_off[i]` = 0 lets output i run when the other conditions allow it.
- R5: `sw_en[i]` = 0 parks output i even when its pin enables it; `sw_en[i]` = 1 leaves the decision to the other conditions.
- R6: In PLL mode `pll_on` is 1 while powered, and the outputs stay parked while `pll_lock` is low, both at startup and after lock is lost.
- R7: In bypass mode `pll_on` stays 0 and the outputs run regardless of `pll_lock`.
- R8: A change of `pwr_good` (after the first start), `pin_off`, `sw_en` or `pll_lock` first sampled at rising edge n takes effect on `out_run` and the legs in the low phase after edge n+1, so the first or last affected high pulse begins at edge n+2 (two output clocks, inside a 1 to 3 clock window); the first start after reset takes one extra clock.
- R9: The gate of each output changes only on a falling clock edge: while running `dif_t` equals the clock and `dif_c` its inverse, while parked both are 0, and no partial pulse appears.
- R10: The outputs are gated independently: a disable on one output never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Asynchronous power-good (1) / power-down (0) request |
| pin_off | input | NOUT | Asynchronous per-output disable pins, 1 parks the output |
| sw_en | input | NOUT | Per-output software enable bits from another clock domain, 0 parks the output |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| byp_strap | input | 1 | Mode strap, 1 selects bypass, 0 selects PLL |
| dif_t | output | NOUT | Gated true leg per output |
| dif_c | output | NOUT | Gated complement leg per output |
| out_run | output | NOUT | Current gate state per output, 1 = toggling |
| pll_on | output | 1 | Registered request to run the PLL |

## Verification
The checker watches, on every cycle, that a disable pin, a cleared software bit or a low power-good seen two edges earlier leaves the output parked, that a missing lock blocks the outputs whenever the PLL is requested, that the PLL request falls during power-down, and that on each clock phase the legs match the gate state, which shows the gate never moves while the clock is high. The one-time sampling of the strap, its retention across power-down exits, the bypass behaviour, the independence of the two outputs and the exact start and stop cycles depend on history that only the bench's directed scenarios establish, so those are shown by its scoreboard.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  // Operating mode frozen at the first power-good rise.
  typedef enum logic {
    MODE_PLL    = 1'b0,
    MODE_BYPASS = 1'b1
  } pll_mode_e;

  // Default synchronizer length for asynchronous controls.
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // Clock source is usable: bypass needs no lock, PLL mode does.
  function automatic logic source_ready(pll_mode_e mode, logic lock);
    return (mode == MODE_BYPASS) || lock;
  endfunction

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   DEPTH   = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Flop chain; stage 0 captures the asynchronous input.
  logic [DEPTH-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[DEPTH-1];

endmodule

// File: rtl/ckg_startup.sv
module ckg_startup
  import ckg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pg_s,
  input  logic      strap_s,
  output logic      started,
  output pll_mode_e mode_q,
  output logic      pll_on
);

  // The strap is captured once on the first synchronized power-good high.
  // Later power-down exits leave started set and the mode untouched.
  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      mode_q  <= MODE_PLL;
      pll_on  <= 1'b0;
    end else begin
      if (pg_s && !started) begin
        started <= 1'b1;
        mode_q  <= strap_s ? MODE_BYPASS : MODE_PLL;
      end
      pll_on <= pg_s && started && (mode_q == MODE_PLL);
    end
  end

endmodule

// File: rtl/ckg_enable_logic.sv
module ckg_enable_logic
  import ckg_pkg::*;
#(
  parameter int unsigned NOUT = 2
) (
  input  logic            pg_s,
  input  logic            started,
  input  pll_mode_e       mode_q,
  input  logic            lock_s,
  input  logic [NOUT-1:0] pin_off_s,
  input  logic [NOUT-1:0] sw_en_s,
  output logic [NOUT-1:0] run_req
);

  // Conditions shared by all outputs.
  logic common_ok;
  assign common_ok = pg_s && started && source_ready(mode_q, lock_s);

  // Per-output qualification: software bit and pin must both allow it.
  for (genvar i = 0; i < NOUT; i++) begin : g_req
    assign run_req[i] = common_ok && sw_en_s[i] && !pin_off_s[i];
  end

endmodule

// File: rtl/ckg_gate_cell.sv
module ckg_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic run_req,
  output logic dif_t,
  output logic dif_c,
  output logic run
);

  // The gate moves only on the falling edge, i.e. at the start of the low
  // phase, so neither leg can be cut short.
  logic gate_q;

  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_req;
  end

  assign dif_t = clk  & gate_q;
  assign dif_c = ~clk & gate_q;
  assign run   = gate_q;

endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import ckg_pkg::*;
#(
  parameter int unsigned NOUT       = 2,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_good,
  input  logic [NOUT-1:0] pin_off,
  input  logic [NOUT-1:0] sw_en,
  input  logic            pll_lock,
  input  logic            byp_strap,
  output logic [NOUT-1:0] dif_t,
  output logic [NOUT-1:0] dif_c,
  output logic [NOUT-1:0] out_run,
  output logic            pll_on
);

  localparam int unsigned PER_W = 2 * NOUT;
  localparam int unsigned GLB_W = 3;
  // Reset values: pins read as disabled, software bits as enabled.
  localparam logic [PER_W-1:0] PER_RST = {{NOUT{1'b1}}, {NOUT{1'b1}}};

  logic [PER_W-1:0] per_s;
  logic [GLB_W-1:0] glb_s;
  logic [NOUT-1:0]  pin_off_s, sw_en_s, run_req;
  logic             pg_s, lock_s, strap_s, started;
  pll_mode_e        mode_q;

  ckg_sync #(.W(PER_W), .DEPTH(SYNC_DEPTH), .RST_VAL(PER_RST)) u_sync_per (
    .clk (clk),
    .rst (rst),
    .d   ({sw_en, pin_off}),
    .q   (per_s)
  );

  ckg_sync #(.W(GLB_W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_sync_glb (
    .clk (clk),
    .rst (rst),
    .d   ({byp_strap, pll_lock, pwr_good}),
    .q   (glb_s)
  );

  assign pin_off_s = per_s[NOUT-1:0];
  assign sw_en_s   = per_s[PER_W-1:NOUT];
  assign pg_s      = glb_s[0];
  assign lock_s    = glb_s[1];
  assign strap_s   = glb_s[2];

  ckg_startup u_startup (
    .clk     (clk),
    .rst     (rst),
    .pg_s    (pg_s),
    .strap_s (strap_s),
    .started (started),
    .mode_q  (mode_q),
    .pll_on  (pll_on)
  );

  ckg_enable_logic #(.NOUT(NOUT)) u_enable (
    .pg_s      (pg_s),
    .started   (started),
    .mode_q    (mode_q),
    .lock_s    (lock_s),
    .pin_off_s (pin_off_s),
    .sw_en_s   (sw_en_s),
    .run_req   (run_req)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    ckg_gate_cell u_gate (
      .clk     (clk),
      .rst     (rst),
      .run_req (run_req[i]),
      .dif_t   (dif_t[i]),
      .dif_c   (dif_c[i]),
      .run     (out_run[i])
    );
  end

endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
module clkout_gate_ctrl_chk #(
  parameter int unsigned NOUT = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_good,
  input logic [NOUT-1:0] pin_off,
  input logic [NOUT-1:0] sw_en,
  input logic            pll_lock,
  input logic [NOUT-1:0] dif_t,
  input logic [NOUT-1:0] dif_c,
  input logic [NOUT-1:0] out_run,
  input logic            pll_on
);

  // Power-down seen two edges ago leaves every output parked (R3, R1).
  p_pd_park_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good, 2) |-> (out_run == '0));

  // PLL request drops after power-down has passed the synchronizer (R1).
  p_pd_pll_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good, 3) |-> !pll_on);

  // Missing lock blocks the outputs whenever the PLL is requested (R6).
  p_lock_block_r6: assert property (@(posedge clk) disable iff (rst)
    (pll_on && !$past(pll_lock, 2)) |-> (out_run == '0));

  for (genvar i = 0; i < NOUT; i++) begin : g_chk
    // Disable pin parks its own output (R4).
    p_pin_park_r4: assert property (@(posedge clk) disable iff (rst)
      $past(pin_off[i], 2) |-> !out_run[i]);

    // Cleared software bit parks its own output (R5).
    p_sw_park_r5: assert property (@(posedge clk) disable iff (rst)
      !$past(sw_en[i], 2) |-> !out_run[i]);
  end

  // Through the high phase the true leg follows the gate and the complement
  // stays low, so the gate did not move while the clock was high (R9).
  p_high_phase_r9: assert property (@(negedge clk) disable iff (rst)
    (dif_t == out_run) && (dif_c == '0));

  // Through the low phase the true leg is low and the complement follows (R9).
  p_low_phase_r9: assert property (@(posedge clk) disable iff (rst)
    (dif_t == '0) && (dif_c == out_run));

endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(.NOUT(NOUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_good (pwr_good),
  .pin_off  (pin_off),
  .sw_en    (sw_en),
  .pll_lock (pll_lock),
  .dif_t    (dif_t),
  .dif_c    (dif_c),
  .out_run  (out_run),
  .pll_on   (pll_on)
);

// File: tb/clkout_gate_ctrl_bench.sv
module clkout_gate_ctrl_bench;

  localparam int NOUT = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            pwr_good = 1'b0;
  logic [NOUT-1:0] pin_off = '0;
  logic [NOUT-1:0] sw_en = '1;
  logic            pll_lock = 1'b0;
  logic            byp_strap = 1'b0;
  logic [NOUT-1:0] dif_t, dif_c, out_run;
  logic            pll_on;

  clkout_gate_ctrl #(.NOUT(NOUT)) u_clkout_gate_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .pin_off   (pin_off),
    .sw_en     (sw_en),
    .pll_lock  (pll_lock),
    .byp_strap (byp_strap),
    .dif_t     (dif_t),
    .dif_c     (dif_c),
    .out_run   (out_run),
    .pll_on    (pll_on)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int              at;
    logic [NOUT-1:0] run;
    logic            pll;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Driver side: schedule an expected state d cycles from now.
  task automatic expect_at(int d, logic [NOUT-1:0] run, logic pll, string tag);
    exp_t e;
    e.at  = cyc + d;
    e.run = run;
    e.pll = pll;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Inputs always change 4 time units after a rising edge.
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  // Monitor: sample 2 time units after the rising edge (clock high).
  always @(posedge clk) begin
    #2;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (e.at != cyc || out_run !== e.run || pll_on !== e.pll) begin
        n_bad++;
        $display("FAIL %s: out_run=%b pll_on=%b, expected out_run=%b pll_on=%b (cycle %0d, due %0d)",
                 e.tag, out_run, pll_on, e.run, e.pll, cyc, e.at);
      end
      n_cmp++;
      if (dif_t !== e.run || dif_c !== '0) begin
        n_bad++;
        $display("FAIL R9 legs in high phase (%s): dif_t=%b dif_c=%b, expected dif_t=%b dif_c=00",
                 e.tag, dif_t, dif_c, e.run);
      end
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    expect_at(2, 2'b00, 1'b0, "R1 reset state");
    step(3);
    pll_lock = 1'b1;
    expect_at(4, 2'b00, 1'b0, "R1 power-good low parks despite lock and enables");
    step(6);

    // PLL mode startup without lock.
    pll_lock  = 1'b0;
    byp_strap = 1'b0;
    pwr_good  = 1'b1;
    expect_at(4, 2'b00, 1'b1, "R6 PLL mode blocked until lock");
    step(6);

    pll_lock = 1'b1;
    expect_at(2, 2'b00, 1'b1, "R8 start not before second clock");
    expect_at(3, 2'b11, 1'b1, "R8 R6 start after lock");
    step(5);

    byp_strap = 1'b1;
    expect_at(4, 2'b11, 1'b1, "R2 strap change ignored after start");
    step(5);

    pin_off = 2'b01;
    expect_at(2, 2'b11, 1'b1, "R8 stop not before second clock");
    expect_at(3, 2'b10, 1'b1, "R4 pin parks output 0");
    step(5);
    pin_off = 2'b00;
    expect_at(3, 2'b11, 1'b1, "R4 pin low lets output 0 run");
    step(5);

    sw_en = 2'b10;
    expect_at(3, 2'b10, 1'b1, "R5 software bit parks output 0");
    step(5);
    sw_en   = 2'b01;
    pin_off = 2'b01;
    expect_at(3, 2'b00, 1'b1, "R5 R4 software parks 1, pin parks 0");
    step(5);
    sw_en   = 2'b11;
    pin_off = 2'b10;
    expect_at(3, 2'b01, 1'b1, "R10 outputs gated independently");
    step(5);
    sw_en   = 2'b01;
    pin_off = 2'b00;
    expect_at(3, 2'b01, 1'b1, "R5 software bit wins over enabling pin");
    step(5);
    sw_en = 2'b11;
    expect_at(3, 2'b11, 1'b1, "R5 software bit restored");
    step(5);

    pll_lock = 1'b0;
    expect_at(3, 2'b00, 1'b1, "R6 lock loss blanks outputs");
    step(5);
    pll_lock = 1'b1;
    expect_at(3, 2'b11, 1'b1, "R6 relock resumes outputs");
    step(5);

    // Power-down and exit with the strap now at bypass.
    pwr_good = 1'b0;
    expect_at(2, 2'b11, 1'b1, "R8 power-down not before second clock");
    expect_at(3, 2'b00, 1'b0, "R3 power-down parks outputs and PLL");
    step(4);
    pin_off = 2'b01;
    step(2);
    pin_off = 2'b00;
    expect_at(3, 2'b00, 1'b0, "R3 pins ignored in power-down");
    step(5);
    pwr_good = 1'b1;
    expect_at(3, 2'b11, 1'b1, "R2 R3 exit keeps PLL mode");
    step(5);

    // Fresh start in bypass mode.
    rst      = 1'b1;
    pwr_good = 1'b0;
    step(3);
    rst      = 1'b0;
    pll_lock = 1'b0;
    step(3);
    pwr_good = 1'b1;
    expect_at(4, 2'b11, 1'b0, "R7 bypass runs without lock");
    step(6);
    pll_lock = 1'b1;
    step(2);
    pll_lock = 1'b0;
    expect_at(3, 2'b11, 1'b0, "R7 lock ignored in bypass");
    step(5);

    byp_strap = 1'b0;
    pwr_good  = 1'b0;
    expect_at(3, 2'b00, 1'b0, "R3 bypass power-down parks");
    step(5);
    pwr_good = 1'b1;
    expect_at(3, 2'b11, 1'b0, "R2 latched bypass kept on exit");
    step(6);

    done = 1'b1;
    if (q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: %0d expected items never compared, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule